// File: doc/BRIEF.md
# Prescaled Up/Down Timer

This block turns a fast system clock into periodic update pulses. A clock-enable strobe from a power-of-two input divider feeds a programmable prescaler. Each prescaler tick advances a main counter that is bounded by an auto-reload limit. The counter either runs upward and wraps (edge mode) or climbs to the limit and then descends back to zero (center mode). A center cycle therefore lasts exactly twice as long as an edge cycle with the same settings.

The divider select, prescale value, reload limit, mode and compare value are presented as level inputs. The timer captures them into active copies when it starts and again on each update event, so a cycle in progress is never disturbed. The outputs are the live count, a one-cycle update pulse, the count direction and a PWM level derived from the compare value.

Top module: `prescaled_timer`

## Requirements
- R1: While reset is asserted and until the first enable, count_o is 0, update_o is 0, dir_down_o is 0 (up) and pwm_o is 0.
- R2: The first clock edge that samples en_i high while the timer is stopped loads all settings, clears the divider, prescaler and counter, and sets the direction to up. Counting starts on the following edge, so the first update_o is seen (D·(P+1)·L)+1 cycles after en_i rises, where L is the cycle length in ticks.
- R3: div_sel_i = k selects a timer input clock of one strobe per 2^k system clocks, for k in 0..3.
- R4: The counter advances once every psc_i+1 timer input clocks.
- R5: In edge mode (center_i = 0) the count runs 0,1,…,ARR and then returns to 0. update_o is high for the cycle in which the count has just returned to 0. The period is D·(P+1)·(ARR+1) system clocks.
- R6: In center mode (center_i = 1) the count runs 0…ARR with dir_down_o = 0, then ARR…0 with dir_down_o = 1. Each endpoint value holds for one tick in each direction, so a full cycle is 2·(ARR+1) ticks long.
- R7: In center mode update_o fires once per full cycle, when the count turns from down back to up at 0. Whenever update_o is high, count_o is 0 and dir_down_o is 0.
- R8: Changes to div_sel_i, psc_i, arr_i, center_i and cmp_i take effect only at the next update event (or at a fresh enable). The running cycle keeps its length.
- R9: pwm_o is high exactly while count_o is below the active compare value. A compare of 0 keeps it low, and a compare above ARR keeps it high.
- R10: While en_i is low, count_o and dir_down_o hold and update_o stays 0. On re-enable the count restarts from 0 with the direction set to up.
- R11: The count and reload limit are 16 bits wide, so ARR = 65535 gives a cycle of 65536 ticks that reaches count 65535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low freezes the timer |
| div_sel_i | input | SEL_W (2) | Input divider exponent k, divide by 2^k |
| psc_i | input | PSC_W (16) | Prescale value P, tick every P+1 timer clocks |
| arr_i | input | CNT_W (16) | Auto-reload limit |
| center_i | input | 1 | 0 = edge mode, 1 = center mode |
| cmp_i | input | CNT_W (16) | PWM compare value |
| count_o | output | CNT_W (16) | Current count |
| update_o | output | 1 | One-cycle update pulse |
| dir_down_o | output | 1 | 1 while counting down |
| pwm_o | output | 1 | High while count_o is below the active compare |

## Verification
The bench builds the block with its default widths: a 16-bit count and prescaler and a 2-bit divider select. The full 16-bit reload limit of 65535 can therefore be run and its wrap observed. All four divider exponents, small random prescale and reload values in both modes, and mid-cycle changes to the settings are compared cycle by cycle against a position-based model. Measured update intervals are also checked against the period formulas.

// File: rtl/timer_pkg.sv
package timer_pkg;
    typedef enum logic {
        MODE_EDGE   = 1'b0,
        MODE_CENTER = 1'b1
    } mode_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;
endpackage

// File: rtl/tmr_clkdiv.sv
module tmr_clkdiv #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CW = (1 << SEL_W) - 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [CW-1:0] limit;

    always_comb begin
        limit = CW'((1 << sel) - 1);
        tick  = run && !clr && (st_q.cnt == limit);
        st_d  = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (run) begin
            st_d.cnt = tick ? '0 : st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);
    typedef struct packed {
        logic [PSC_W-1:0] cnt;
    } psc_st_t;

    psc_st_t st_d, st_q;

    always_comb begin
        tick = step && !clr && (st_q.cnt == psc);
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (step) begin
            st_d.cnt = tick ? '0 : st_q.cnt + PSC_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic [CNT_W-1:0] arr,
    input  mode_e            mode,
    output logic [CNT_W-1:0] count,
    output dir_e             dir,
    output logic             upd,
    output logic             wrap
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        dir_e             dir;
        logic             upd;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.upd = 1'b0;
        if (clr) begin
            st_d.cnt = '0;
            st_d.dir = DIR_UP;
        end else if (step) begin
            if (mode == MODE_EDGE) begin
                if (st_q.cnt == arr) begin
                    st_d.cnt = '0;
                    st_d.upd = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end else if (st_q.dir == DIR_UP) begin
                if (st_q.cnt == arr) st_d.dir = DIR_DOWN;
                else                 st_d.cnt = st_q.cnt + CNT_W'(1);
            end else begin
                if (st_q.cnt == '0) begin
                    st_d.dir = DIR_UP;
                    st_d.upd = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
        end
        wrap  = st_d.upd;
        count = st_q.cnt;
        dir   = st_q.dir;
        upd   = st_q.upd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: '0, dir: DIR_UP, upd: 1'b0};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
    import timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [SEL_W-1:0] div_sel_i,
    input  logic [PSC_W-1:0] psc_i,
    input  logic [CNT_W-1:0] arr_i,
    input  logic             center_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic [CNT_W-1:0] count_o,
    output logic             update_o,
    output logic             dir_down_o,
    output logic             pwm_o
);
    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [PSC_W-1:0] psc;
        logic [CNT_W-1:0] arr;
        logic             center;
        logic [CNT_W-1:0] cmp;
    } cfg_t;

    typedef struct packed {
        logic running;
        cfg_t act;
    } top_st_t;

    top_st_t st_d, st_q;
    logic    load, run, div_tick, psc_tick, wrap;
    mode_e   mode;
    dir_e    dir;

    // Settings are captured on start and at each update event only.
    always_comb begin
        load       = en_i && !st_q.running;
        run        = en_i && st_q.running;
        mode       = st_q.act.center ? MODE_CENTER : MODE_EDGE;
        st_d       = st_q;
        st_d.running = en_i;
        if (load || wrap) begin
            st_d.act = '{sel: div_sel_i, psc: psc_i, arr: arr_i,
                         center: center_i, cmp: cmp_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    tmr_clkdiv #(.SEL_W(SEL_W)) u_div (
        .clk(clk), .rst_n(rst_n), .clr(load), .run(run),
        .sel(st_q.act.sel), .tick(div_tick)
    );

    tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .clr(load), .step(div_tick),
        .psc(st_q.act.psc), .tick(psc_tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(load), .step(psc_tick),
        .arr(st_q.act.arr), .mode(mode), .count(count_o), .dir(dir),
        .upd(update_o), .wrap(wrap)
    );

    assign dir_down_o = (dir == DIR_DOWN);
    assign pwm_o      = (count_o < st_q.act.cmp);
endmodule

// File: rtl/prescaled_timer_checker.sv
module prescaled_timer_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_i,
    input logic [CNT_W-1:0] count_o,
    input logic             update_o,
    input logic             dir_down_o
);
    a_r7_update_at_bottom: assert property (@(posedge clk) disable iff (!rst_n)
        update_o |-> (count_o == '0 && !dir_down_o));

    a_r10_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> ($stable(count_o) && $stable(dir_down_o) && !update_o));

    a_r2_start_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_i) |=> (count_o == '0 && !dir_down_o && !update_o));

    a_r5_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(count_o) |-> (count_o == CNT_W'($past(count_o) + CNT_W'(1))
                               || count_o == CNT_W'($past(count_o) - CNT_W'(1))
                               || count_o == '0));

    a_r6_turn_holds_top: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dir_down_o) |-> $stable(count_o));
endmodule

bind prescaled_timer prescaled_timer_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .count_o(count_o),
    .update_o(update_o), .dir_down_o(dir_down_o)
);

// File: tb/sim_prescaled_timer.sv
module sim_prescaled_timer;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 16;
    localparam int PSC_W = 16;
    localparam int SEL_W = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en_i = 1'b0;
    logic [SEL_W-1:0] div_sel_i = '0;
    logic [PSC_W-1:0] psc_i = '0;
    logic [CNT_W-1:0] arr_i = '0;
    logic             center_i = 1'b0;
    logic [CNT_W-1:0] cmp_i = '0;
    logic [CNT_W-1:0] count_o;
    logic             update_o, dir_down_o, pwm_o;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    // reference model state: position within the cycle, source clocks within the tick
    int  m_run, m_sub, m_pos, m_upd, m_count, m_down;
    int  a_sel, a_p, a_a, a_c, a_cmp;

    always #(CLK_PERIOD/2) clk = ~clk;

    prescaled_timer #(.CNT_W(CNT_W), .PSC_W(PSC_W), .SEL_W(SEL_W)) u0 (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .div_sel_i(div_sel_i),
        .psc_i(psc_i), .arr_i(arr_i), .center_i(center_i), .cmp_i(cmp_i),
        .count_o(count_o), .update_o(update_o), .dir_down_o(dir_down_o),
        .pwm_o(pwm_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int cycle_ticks();
        return (a_c != 0) ? 2 * (a_a + 1) : (a_a + 1);
    endfunction

    task automatic capture();
        a_sel = int'(div_sel_i); a_p = int'(psc_i); a_a = int'(arr_i);
        a_c = int'(center_i);    a_cmp = int'(cmp_i);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_sub = 0; m_pos = 0; m_upd = 0;
            a_sel = 0; a_p = 0; a_a = 0; a_c = 0; a_cmp = 0;
        end else begin
            m_upd = 0;
            if (!en_i) begin
                m_run = 0;
            end else if (m_run == 0) begin
                m_run = 1; m_sub = 0; m_pos = 0;
                capture();
            end else begin
                m_sub++;
                if (m_sub == (1 << a_sel) * (a_p + 1)) begin
                    m_sub = 0;
                    m_pos++;
                    if (m_pos == cycle_ticks()) begin
                        m_pos = 0; m_upd = 1;
                        capture();
                    end
                end
            end
        end
        if (a_c != 0 && m_pos > a_a) begin
            m_count = 2 * a_a + 1 - m_pos; m_down = 1;
        end else begin
            m_count = m_pos; m_down = 0;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(int'(count_o) == m_count, "R5/R6 count", count_o, m_count);
            chk(int'(dir_down_o) == m_down, "R6 direction", dir_down_o, m_down);
            chk(int'(update_o) == m_upd, "R7 update", update_o, m_upd);
            chk(int'(pwm_o) == int'(m_count < a_cmp), "R9 pwm", pwm_o, int'(m_count < a_cmp));
        end
    end

    task automatic wait_upd(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!update_o);
    endtask

    task automatic restart(input int sel, input int p, input int a, input int c, input int cmp);
        @(negedge clk);
        en_i = 1'b0;
        div_sel_i = SEL_W'(sel); psc_i = PSC_W'(p); arr_i = CNT_W'(a);
        center_i = c[0]; cmp_i = CNT_W'(cmp);
        @(negedge clk);
        en_i = 1'b1;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int n, hi, dn, mx;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(count_o == '0 && !update_o && !dir_down_o && !pwm_o, "R1 reset outputs", count_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(count_o == '0 && !dir_down_o && !pwm_o, "R1 idle after reset", count_o, 0);

        // R2 + R5: edge mode, /1, P=1, ARR=9 -> 20 clocks per period
        restart(0, 1, 9, 0, 5);
        @(negedge clk);
        chk(count_o == '0 && !dir_down_o, "R2 cleared on load", count_o, 0);
        wait_upd(n);
        chk(n == 20, "R2 first update latency", n + 1, 21);
        wait_upd(n);
        chk(n == 20, "R5 edge period", n, 20);

        // R8: change ARR mid-cycle; running cycle keeps 20, next one uses 10
        repeat (3) @(negedge clk);
        arr_i = CNT_W'(4);
        wait_upd(n);
        chk(n == 17, "R8 running cycle untouched", n, 17);
        wait_upd(n);
        chk(n == 10, "R8 new limit after update", n, 10);

        // R6: center mode, /2, P=2, ARR=3 -> 48 clocks, half counting down
        restart(1, 2, 3, 1, 2);
        wait_upd(n);
        dn = 0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (dir_down_o) dn++;
        end while (!update_o);
        chk(n == 48, "R6 center period", n, 48);
        chk(dn == 24, "R6 down half", dn, 24);

        // R9: compare 0 keeps pwm low; compare above ARR keeps it high
        cmp_i = '0;
        wait_upd(n);
        hi = 0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (pwm_o) hi++;
        end while (!update_o);
        chk(hi == 0, "R9 compare zero low", hi, 0);
        cmp_i = CNT_W'(4);
        wait_upd(n);
        hi = 0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (pwm_o) hi++;
        end while (!update_o);
        chk(hi == n, "R9 compare above ARR high", hi, n);

        // R10: freeze then restart from 0 going up
        repeat (30) @(negedge clk);
        en_i = 1'b0;
        @(negedge clk);
        mx = int'(count_o);
        repeat (5) @(negedge clk);
        chk(int'(count_o) == mx && !update_o, "R10 frozen", count_o, mx);
        en_i = 1'b1;
        @(negedge clk);
        chk(count_o == '0 && !dir_down_o, "R10 restart at zero up", count_o, 0);

        // R3/R4/R5/R6: random settings against the period formula
        for (int i = 0; i < 8; i++) begin
            int s, p, a, c, exp;
            s = int'($urandom_range(3, 0));
            p = int'($urandom_range(5, 0));
            a = int'($urandom_range(20, 0));
            c = int'($urandom_range(1, 0));
            if (i < 4) s = i;
            exp = (1 << s) * (p + 1) * (a + 1) * (c + 1);
            restart(s, p, a, c, a / 2);
            wait_upd(n);
            chk(n == exp + 1, "R3 divider start latency", n, exp + 1);
            wait_upd(n);
            if (c != 0) chk(n == exp, "R4 R6 center random period", n, exp);
            else        chk(n == exp, "R4 R5 edge random period", n, exp);
        end

        // R11: full 16-bit reload limit
        restart(0, 0, 65535, 0, 100);
        mx = 0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (int'(count_o) > mx) mx = int'(count_o);
        end while (!update_o);
        chk(n == 65537, "R11 full width latency", n, 65537);
        chk(mx == 65535, "R11 top count reached", mx, 65535);

        finish_run();
    end
endmodule